// File: doc/BRIEF.md
# Four-Level Transmit Symbol Mapper with Three-Tap De-Emphasis

This block sits at the transmit end of a serial link. Each cycle in which `in_valid` is high it takes one pair of bits and turns it into one four-level symbol using a Gray code. When `two_level` is high the second bit of the pair is forced low, so that only the two outer levels appear. The symbol stream then runs through a three-tap transmit FIR that shapes it for the channel. One tap looks ahead at the next symbol, one weights the current symbol, and one looks back at the previous symbol. The result comes out as one signed drive word per symbol, at full precision. The analog driver that follows scales the word.

The three tap weights are signed fixed-point numbers with 8 fractional bits. Software or a sequencer presents a new set on the coefficient inputs and pulses `coef_load`. The set is held aside and applied as a whole at the next accepted symbol, so no drive word mixes two sets. The block checks the active set against two rules: the three weights must sum to one, and the main weight must exceed the sum of the two side weights. `cfg_err` reports a set that breaks either rule. With the reset weights (0, 1, 0) the filter passes symbols through unchanged. The set (0.075, 0.75, 0.175) lowers the low-frequency level to one half, which is about 6 dB of de-emphasis.

Top module: `pam4_tx_fir`

## Requirements
- R1: The pair is mapped with `in_bits[1]` (the earlier bit in time) as MSB and `in_bits[0]` as LSB. The codes map as 2'b00 to -3, 2'b01 to -1, 2'b11 to +1 and 2'b10 to +3.
- R2: While `two_level` is high, the LSB is treated as 0 whatever `in_bits[0]` is. Only -3 (MSB 0) and +3 (MSB 1) reach the filter.
- R3: The drive word for a centre symbol x[n] is C0*x[n] - Cpre*x[n+1] - Cpost*x[n-1]. Each coefficient is a signed 10-bit number with 8 fractional bits (256 = 1.0). The word is the exact signed sum on 15 bits, so it is 256 times the real-valued result.
- R4: `out_valid` rises in the cycle after each accepted symbol. The word shown then belongs to the symbol accepted one acceptance earlier, so the newest symbol serves as x[n+1].
- R5: In a cycle with `in_valid` low, no symbol is accepted. `out_valid` is low in the following cycle, and `out_word` and the delay line keep their values.
- R6: After reset, `out_valid` is 0 and `out_word` is 0. Both delay-line entries hold level 0. The active set is Cpre=0, C0=256, Cpost=0, and `cfg_err` is 0.
- R7: A `coef_load` pulse captures all three coefficient inputs at once. The captured set is used from the first symbol accepted after the pulse cycle on. A symbol accepted in the pulse cycle itself still uses the earlier set.
- R8: `cfg_err` is 1 exactly when the active set has Cpre+C0+Cpost not equal to 256, or C0-Cpre-Cpost not greater than 0. It follows the active set, so it changes only in the cycle after an acceptance that applied a new set.
- R9: With the pass-through set, each drive word equals 256 times the level of the symbol accepted one acceptance earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A bit pair is presented this cycle |
| in_bits | input | 2 | Bit pair; bit 1 is the earlier bit (MSB) |
| two_level | input | 1 | Force the LSB low (two-level signalling) |
| coef_load | input | 1 | Capture the coefficient inputs as the pending set |
| coef_pre | input | 10 | Pre-cursor weight, signed, 8 fractional bits |
| coef_main | input | 10 | Main weight, signed, 8 fractional bits |
| coef_post | input | 10 | Post-cursor weight, signed, 8 fractional bits |
| out_valid | output | 1 | A drive word is present |
| out_word | output | 15 | Signed drive word, scaled by 256 |
| cfg_err | output | 1 | The active coefficient set breaks a rule |

## Verification
Every result is due one clock edge after the cycle in which its stimulus is presented. `out_valid` and `out_word` follow the accepting edge. `cfg_err` follows the edge that applies a pending set. The bench drives each cycle's inputs at the falling edge and updates its model in the same step. It steps over exactly one rising edge and compares all three outputs at the next falling edge. The model keeps its own delay line and coefficient sets. A word therefore always pairs the centre symbol from one acceptance back with the newest symbol. A load is counted only from the acceptance after its pulse.

// File: rtl/pam4_tx_pkg.sv
`timescale 1ns/1ps
package pam4_tx_pkg;

  localparam int LVL_W = 3;
  typedef logic signed [LVL_W-1:0] level_t;

  // Gray table: adjacent levels differ in one bit
  function automatic level_t gray_to_level(input logic msb, input logic lsb);
    level_t lv;
    unique case ({msb, lsb})
      2'b00:   lv = level_t'(-3);
      2'b01:   lv = level_t'(-1);
      2'b11:   lv = level_t'(1);
      default: lv = level_t'(3);
    endcase
    return lv;
  endfunction

endpackage

// File: rtl/pam4_gray_mapper.sv
`timescale 1ns/1ps
module pam4_gray_mapper
  import pam4_tx_pkg::*;
(
  input  logic [1:0] pair,
  input  logic       two_level,
  output level_t     level
);

  logic lsb_eff;

  assign lsb_eff = pair[0] & ~two_level;
  assign level   = gray_to_level(pair[1], lsb_eff);

endmodule

// File: rtl/pam4_coef_bank.sv
`timescale 1ns/1ps
module pam4_coef_bank #(
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     load,
  input  logic signed [COEF_W-1:0] in_pre,
  input  logic signed [COEF_W-1:0] in_main,
  input  logic signed [COEF_W-1:0] in_post,
  output logic signed [COEF_W-1:0] use_pre,
  output logic signed [COEF_W-1:0] use_main,
  output logic signed [COEF_W-1:0] use_post,
  output logic                     cfg_err
);

  localparam int SUM_W = COEF_W + 2;
  localparam int UNITY = 1 << FRAC_W;

  logic signed [COEF_W-1:0] pend_pre, pend_main, pend_post;
  logic signed [COEF_W-1:0] act_pre, act_main, act_post;
  logic                     pend_f;

  function automatic logic coef_ok(input logic signed [COEF_W-1:0] p,
                                   input logic signed [COEF_W-1:0] m,
                                   input logic signed [COEF_W-1:0] q);
    logic signed [SUM_W-1:0] total, margin;
    total  = SUM_W'(p) + SUM_W'(m) + SUM_W'(q);
    margin = SUM_W'(m) - SUM_W'(p) - SUM_W'(q);
    return (total == SUM_W'(UNITY)) && (margin > SUM_W'(0));
  endfunction

  // a pending set wins at the next acceptance
  assign use_pre  = pend_f ? pend_pre  : act_pre;
  assign use_main = pend_f ? pend_main : act_main;
  assign use_post = pend_f ? pend_post : act_post;
  assign cfg_err  = ~coef_ok(act_pre, act_main, act_post);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_pre   <= '0;
      act_main  <= COEF_W'(UNITY);
      act_post  <= '0;
      pend_pre  <= '0;
      pend_main <= COEF_W'(UNITY);
      pend_post <= '0;
      pend_f    <= 1'b0;
    end else begin
      if (accept) begin
        act_pre  <= use_pre;
        act_main <= use_main;
        act_post <= use_post;
        pend_f   <= 1'b0;
      end
      if (load) begin
        pend_pre  <= in_pre;
        pend_main <= in_main;
        pend_post <= in_post;
        pend_f    <= 1'b1;
      end
    end
  end

  // R7: the active set moves only on an acceptance
  a_r7_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(act_pre) && $stable(act_main) && $stable(act_post)));

  // R7: a set loaded earlier is the one applied at the acceptance
  a_r7_pending_applied: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && pend_f) |=> (act_main == $past(pend_main) && act_pre == $past(pend_pre)));

  // R8: the flag can only change after an acceptance
  a_r8_err_moves_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cfg_err));

endmodule

// File: rtl/pam4_fir3.sv
`timescale 1ns/1ps
module pam4_fir3
  import pam4_tx_pkg::*;
#(
  parameter int COEF_W = 10,
  parameter int OUT_W  = COEF_W + LVL_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  level_t                   nxt_level,
  input  logic signed [COEF_W-1:0] c_pre,
  input  logic signed [COEF_W-1:0] c_main,
  input  logic signed [COEF_W-1:0] c_post,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_word
);

  level_t cur_level, prv_level;
  logic signed [OUT_W-1:0] tap_sum;

  // side taps subtract: main*cur - pre*next - post*prev
  function automatic logic signed [OUT_W-1:0] shape(
      input logic signed [COEF_W-1:0] cp, input logic signed [COEF_W-1:0] cm,
      input logic signed [COEF_W-1:0] cq,
      input level_t nx, input level_t cu, input level_t pv);
    logic signed [OUT_W-1:0] w_main, w_pre, w_post;
    w_main = OUT_W'(cm) * OUT_W'(cu);
    w_pre  = OUT_W'(cp) * OUT_W'(nx);
    w_post = OUT_W'(cq) * OUT_W'(pv);
    return w_main - w_pre - w_post;
  endfunction

  assign tap_sum = shape(c_pre, c_main, c_post, nxt_level, cur_level, prv_level);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_level <= '0;
      prv_level <= '0;
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= accept;
      if (accept) begin
        out_word  <= tap_sum;
        prv_level <= cur_level;
        cur_level <= nxt_level;
      end
    end
  end

  // R4: every acceptance yields a word one cycle later
  a_r4_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  // R5: a stalled cycle produces no word and keeps the last one
  a_r5_no_valid_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !out_valid);
  a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(out_word) && $stable(cur_level) && $stable(prv_level)));

  // R4: the newest symbol becomes the centre symbol
  a_r4_line_shift: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (cur_level == $past(nxt_level) && prv_level == $past(cur_level)));

endmodule

// File: rtl/pam4_tx_fir.sv
`timescale 1ns/1ps
module pam4_tx_fir
  import pam4_tx_pkg::*;
#(
  parameter int COEF_W = 10,
  parameter int FRAC_W = 8,
  parameter int OUT_W  = COEF_W + LVL_W + 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [1:0]               in_bits,
  input  logic                     two_level,
  input  logic                     coef_load,
  input  logic signed [COEF_W-1:0] coef_pre,
  input  logic signed [COEF_W-1:0] coef_main,
  input  logic signed [COEF_W-1:0] coef_post,
  output logic                     out_valid,
  output logic signed [OUT_W-1:0]  out_word,
  output logic                     cfg_err
);

  level_t                   sym_level;
  logic signed [COEF_W-1:0] eff_pre, eff_main, eff_post;

  pam4_gray_mapper u_map (
    .pair      (in_bits),
    .two_level (two_level),
    .level     (sym_level)
  );

  pam4_coef_bank #(.COEF_W(COEF_W), .FRAC_W(FRAC_W)) u_coef (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (in_valid),
    .load     (coef_load),
    .in_pre   (coef_pre),
    .in_main  (coef_main),
    .in_post  (coef_post),
    .use_pre  (eff_pre),
    .use_main (eff_main),
    .use_post (eff_post),
    .cfg_err  (cfg_err)
  );

  pam4_fir3 #(.COEF_W(COEF_W), .OUT_W(OUT_W)) u_fir (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (in_valid),
    .nxt_level (sym_level),
    .c_pre     (eff_pre),
    .c_main    (eff_main),
    .c_post    (eff_post),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  // R1: the mapper yields only the four odd levels
  a_r1_odd_level: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (sym_level == 3 || sym_level == 1 || sym_level == -1 || sym_level == -3));

  // R2: two-level mode reaches the filter with outer levels only
  a_r2_outer_only: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && two_level) |-> (sym_level == 3 || sym_level == -3));

endmodule

// File: tb/pam4_tx_fir_test.sv
`timescale 1ns/1ps
module pam4_tx_fir_test;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic [1:0]        in_bits = 2'b00;
  logic              two_level = 1'b0;
  logic              coef_load = 1'b0;
  logic signed [9:0] coef_pre = '0, coef_main = '0, coef_post = '0;
  logic              out_valid;
  logic signed [14:0] out_word;
  logic              cfg_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  int m_cur = 0, m_prv = 0;
  int a_pre = 0, a_main = 256, a_post = 0;
  int p_pre = 0, p_main = 256, p_post = 0;
  bit p_flag = 0;
  int e_word = 0;
  bit e_valid = 0;

  always #2.5 clk = ~clk;

  pam4_tx_fir uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bits(in_bits),
    .two_level(two_level), .coef_load(coef_load), .coef_pre(coef_pre),
    .coef_main(coef_main), .coef_post(coef_post), .out_valid(out_valid),
    .out_word(out_word), .cfg_err(cfg_err)
  );

  function automatic int ref_level(input logic [1:0] b, input bit two);
    bit lo;
    lo = b[0] && !two;
    if (b[1]) return lo ? 1 : 3;
    return lo ? -1 : -3;
  endfunction

  function automatic bit ref_err(input int p, input int m, input int q);
    return (p + m + q != 256) || (m - p - q <= 0);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, model, one rising edge, compare
  task automatic step(input bit v, input logic [1:0] b, input bit two,
                      input bit ld, input int cp, input int cm, input int cq,
                      input string tag);
    int lv;
    in_valid = v; in_bits = b; two_level = two; coef_load = ld;
    coef_pre = 10'(cp); coef_main = 10'(cm); coef_post = 10'(cq);
    e_valid = v;
    if (v) begin
      lv = ref_level(b, two);
      if (p_flag) begin
        a_pre = p_pre; a_main = p_main; a_post = p_post; p_flag = 0;
      end
      e_word = a_main * m_cur - a_pre * lv - a_post * m_prv;
      m_prv = m_cur; m_cur = lv;
    end
    if (ld) begin
      p_pre = cp; p_main = cm; p_post = cq; p_flag = 1;
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " valid"}, int'(out_valid), int'(e_valid));
    check({tag, " word"}, int'(out_word), e_word);
    check({tag, " R8 err"}, int'(cfg_err), int'(ref_err(a_pre, a_main, a_post)));
  endtask

  task automatic sym(input logic [1:0] b, input bit two, input string tag);
    step(1'b1, b, two, 1'b0, 0, 0, 0, tag);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R6: reset state
    check("R6 reset valid", int'(out_valid), 0);
    check("R6 reset word", int'(out_word), 0);
    check("R6 reset err", int'(cfg_err), 0);

    // R6/R9: first word comes from the cleared line
    sym(2'b10, 1'b0, "R6 first word");
    // R1 each code, R9 pass-through (word is previous symbol * 256)
    sym(2'b00, 1'b0, "R1 R9 code10");
    sym(2'b01, 1'b0, "R1 R9 code00");
    sym(2'b11, 1'b0, "R1 R9 code01");
    sym(2'b10, 1'b0, "R1 R9 code11");
    check("R1 code10 direct", int'(out_word), 256);
    sym(2'b00, 1'b0, "R1 R9 code10b");
    check("R1 code10 to +3", int'(out_word), 768);

    // R5 stalls hold the word and the line
    step(1'b0, 2'b11, 1'b0, 1'b0, 0, 0, 0, "R5 stall a");
    step(1'b0, 2'b01, 1'b1, 1'b0, 0, 0, 0, "R5 stall b");
    sym(2'b01, 1'b0, "R5 after stall");
    check("R5 centre kept", int'(out_word), -768);

    // R9 random pass-through
    for (int i = 0; i < 60; i++)
      step(($urandom % 4) != 0, 2'($urandom), 1'b0, 1'b0, 0, 0, 0, "R9 random");

    // R2 two-level with LSB set
    sym(2'b11, 1'b1, "R2 lsb masked");
    sym(2'b01, 1'b1, "R2 lsb masked b");
    check("R2 11 gives +3", int'(out_word), 768);
    for (int i = 0; i < 40; i++)
      step(1'b1, 2'($urandom), 1'b1, 1'b0, 0, 0, 0, "R2 random");

    // R7 load in an idle cycle, R3 6 dB set
    step(1'b0, 2'b00, 1'b0, 1'b1, 19, 192, 45, "R7 load idle");
    sym(2'b10, 1'b0, "R7 R3 first new");
    sym(2'b10, 1'b0, "R3 de-emph");
    sym(2'b10, 1'b0, "R3 de-emph run");
    check("R3 steady +3", int'(out_word), 384);
    sym(2'b00, 1'b0, "R3 edge");
    check("R3 before edge", int'(out_word), 3*192 + 3*19 - 3*45);
    for (int i = 0; i < 60; i++)
      step(($urandom % 3) != 0, 2'($urandom), 1'b0, 1'b0, 0, 0, 0, "R3 random");

    // R7 load in an accepting cycle: that symbol keeps the old set
    step(1'b1, 2'b10, 1'b0, 1'b1, 0, 256, 0, "R7 load same cycle");
    step(1'b1, 2'b10, 1'b0, 1'b0, 0, 0, 0, "R7 new set applied");

    // R8 sum rule broken, then dominance broken, then restored
    step(1'b1, 2'b00, 1'b0, 1'b1, 10, 200, 10, "R8 load bad sum");
    sym(2'b01, 1'b0, "R8 bad sum active");
    check("R8 bad sum flag", int'(cfg_err), 1);
    step(1'b1, 2'b11, 1'b0, 1'b1, 100, 60, 96, "R8 load bad dom");
    sym(2'b10, 1'b0, "R8 bad dom active");
    check("R8 bad dom flag", int'(cfg_err), 1);
    step(1'b0, 2'b00, 1'b0, 1'b1, 64, 128, 64, "R8 load margin zero");
    sym(2'b11, 1'b0, "R8 margin zero");
    check("R8 zero margin flag", int'(cfg_err), 1);
    step(1'b0, 2'b00, 1'b0, 1'b1, -20, 256, 20, "R8 load signed ok");
    sym(2'b00, 1'b0, "R8 R3 signed taps");
    check("R8 signed ok flag", int'(cfg_err), 0);

    // R7 R3 random coefficient sets mixed with traffic
    for (int i = 0; i < 200; i++) begin
      int cp, cq;
      bit ld;
      ld = ($urandom % 8) == 0;
      cp = int'($urandom % 64) - 8;
      cq = int'($urandom % 80) - 8;
      step(($urandom % 4) != 0, 2'($urandom), bit'($urandom % 5 == 0), ld,
           cp, 256 - cp - cq + (($urandom % 6 == 0) ? 3 : 0), cq, "R7 R3 mixed");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule